// File: doc/BRIEF.md
# Dual-Input Non-Retriggerable Pulse Generator

This block is a clocked one-shot. It watches two trigger lines of opposite polarity and an active-low clear. When a trigger is accepted it drives `pulse_o` high for a set number of clock cycles, and `pulse_n_o` always carries the inverse. The number of cycles comes from `width_i`. It is sampled once, in the cycle the pulse starts. A clock-cycle count takes the place of an analog timing network.

`fall_trig_i` fires on a high-to-low change, but only while `rise_trig_i` is high. `rise_trig_i` fires on a low-to-high change, but only while `fall_trig_i` is low. Each line therefore acts as an enable for the other. A running pulse cannot be restarted.

Pulling `clr_n_i` low ends a pulse at once and holds the output idle. Releasing `clr_n_i` can itself start a pulse when both trigger lines are at their fired levels, provided an internal arming flag was set beforehand. That flag is set by either trigger line resting at its idle level while `clr_n_i` is high.

All three control lines pass through a two-flop synchroniser before edge detection. A change that is set up before rising clock edge k is acted on at edge k+2, so `pulse_o` is high from edge k+2. Edges are recognised only from the third clock edge after reset onward.

Top module: `dual_trig_oneshot`

## Requirements
- R1: After reset, `pulse_o` is 0 and `pulse_n_o` is 1, and they stay that way until a qualifying trigger arrives. Holding idle inputs through reset release causes no pulse.
- R2: In every cycle, `pulse_n_o` equals the inverse of `pulse_o`.
- R3: A 1-to-0 change on `fall_trig_i` starts a pulse when all of the following hold: `rise_trig_i` is 1, `clr_n_i` is 1, and no pulse is running. If the change is set up before clock edge k, `pulse_o` is 1 after edge k+2.
- R4: A 0-to-1 change on `rise_trig_i` starts a pulse, with the same latency as R3, when all of the following hold: `fall_trig_i` is 0, `clr_n_i` is 1, and no pulse is running.
- R5: While `fall_trig_i` is 1, a rising `rise_trig_i` starts no pulse. While `rise_trig_i` is 0, a falling `fall_trig_i` starts no pulse.
- R6: A pulse lasts exactly N clock cycles, where N is the value of `width_i` in the start cycle, and a value of 0 counts as 1. A change of `width_i` during a pulse has no effect on that pulse.
- R7: While a pulse runs, any activity on `fall_trig_i` and `rise_trig_i` neither restarts nor lengthens it. The output pulse length does not depend on how long the trigger level is held.
- R8: `clr_n_i` at 0 forces `pulse_o` to 0 within the same latency as R3 (after edge k+2). While `clr_n_i` stays at 0, no trigger can start a pulse.
- R9: A 0-to-1 change on `clr_n_i` starts a pulse when all of the following hold: `fall_trig_i` is 0, `rise_trig_i` is 1, and the arming flag is set.
- R10: The arming flag is set whenever `clr_n_i` is 1 and either `fall_trig_i` is 1 or `rise_trig_i` is 0. It is cleared when a pulse starts, and it holds its value while `clr_n_i` is 0. A clear release with an unarmed flag starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fall_trig_i | input | 1 | Trigger on falling change, enable for the rising trigger |
| rise_trig_i | input | 1 | Trigger on rising change, enable for the falling trigger |
| clr_n_i | input | 1 | Active-low overriding clear; its rising change can fire |
| width_i | input | WIDTH_W | Pulse length in clock cycles, sampled at start |
| pulse_o | output | 1 | Pulse output, high while timing |
| pulse_n_o | output | 1 | Inverse of pulse_o |

## Verification
A wrong arming flag shows at the ports only on the next clear release with both trigger lines at their fired levels. Such a release either produces an extra pulse or misses a pulse, two edges after the release. A wrong timer count shows up as a pulse that is a cycle too short or too long, as soon as that pulse ends. A wrong edge history shows up as a spurious or missing start within three cycles of the input change. The bench therefore mixes directed clear-release cases with random traffic, and compares the outputs against a cycle-level model every cycle.

// File: rtl/oneshot_pkg.sv
// Shared types for the dual-input one-shot.
// Assumes the three control lines are bundled as one packed struct.
package oneshot_pkg;
    // Bit order is used by the synchroniser vector: [2]=fall, [1]=rise, [0]=clear.
    typedef struct packed {
        logic fall_trig;
        logic rise_trig;
        logic clr_n;
    } ctrl_lines_t;

    localparam int CTRL_W = $bits(ctrl_lines_t);
endpackage

// File: rtl/oneshot_sync.sv
// Multi-bit synchroniser with a one-sample history register.
// Each bit passes through STAGES flops; prev_o holds the previous synced sample.
// valid_o rises once the chain and the history hold real samples taken after reset.
// Assumes STAGES >= 2 and that bits are independent (no bus coherency needed).
module oneshot_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o,
    output logic         valid_o
);
    localparam int VC_MAX = STAGES + 1;
    localparam int VC_W   = $clog2(VC_MAX + 1);

    logic [VC_W-1:0] vcnt_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        // Shift the raw input through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], din[i]};
        end
        assign cur_o[i] = chain_q[STAGES-1];
    end

    // Keep the previous synced sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_o <= '0;
        else        prev_o <= cur_o;
    end

    // Count clocks since reset until the whole pipeline holds real samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                         vcnt_q <= '0;
        else if (vcnt_q != VC_W'(VC_MAX))   vcnt_q <= vcnt_q + 1'b1;
    end

    assign valid_o = (vcnt_q == VC_W'(VC_MAX));
endmodule

// File: rtl/oneshot_trigger.sv
// Trigger qualification and arming flag.
// Decides in each cycle whether a pulse starts, from the synced lines and their
// previous samples. It covers the falling trigger gated by the rise line, the
// rising trigger gated by the fall line, and the clear release gated by the
// arming flag. Assumes busy_i is high for every cycle of a running pulse.
module oneshot_trigger
    import oneshot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_i,
    input  ctrl_lines_t cur_i,
    input  ctrl_lines_t prev_i,
    input  logic        busy_i,
    output logic        fire_o
);
    logic arm_q;
    logic fall_hit, rise_hit, clr_hit;
    logic arm_set;

    // Qualify each trigger source against the levels of the others.
    always_comb begin
        fall_hit = prev_i.fall_trig & ~cur_i.fall_trig & cur_i.rise_trig & cur_i.clr_n;
        rise_hit = ~prev_i.rise_trig & cur_i.rise_trig & ~cur_i.fall_trig & cur_i.clr_n;
        clr_hit  = ~prev_i.clr_n & cur_i.clr_n & ~cur_i.fall_trig & cur_i.rise_trig & arm_q;
        fire_o   = valid_i & ~busy_i & (fall_hit | rise_hit | clr_hit);
        arm_set  = cur_i.clr_n & (cur_i.fall_trig | ~cur_i.rise_trig);
    end

    // Arming flag: cleared by a start, set by an idle level under released clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          arm_q <= 1'b0;
        else if (valid_i) begin
            if (fire_o)       arm_q <= 1'b0;
            else if (arm_set) arm_q <= 1'b1;
        end
    end

    // R10: a start leaves the flag cleared in the next cycle.
    assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !arm_q);

    // R10: the flag keeps its value while clear is held low.
    assert_arm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !cur_i.clr_n) |=> $stable(arm_q));
endmodule

// File: rtl/oneshot_timer.sv
// Non-retriggerable pulse timer.
// Loads the cycle count on a start and counts down to the end of the pulse.
// A low clear level ends the pulse at once. A start is accepted only while idle,
// and that rule is enforced by the caller through the busy feedback.
module oneshot_timer #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n_i,
    input  logic               fire_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               pulse_o
);
    logic [WIDTH_W-1:0] cnt_q;
    logic [WIDTH_W-1:0] load_val;

    // A zero width still gives one cycle: the load value is the length minus one.
    always_comb begin
        load_val = (width_i == '0) ? '0 : width_i - 1'b1;
    end

    // Pulse state and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
            cnt_q   <= '0;
        end else if (!clr_n_i) begin
            pulse_o <= 1'b0;
            cnt_q   <= '0;
        end else if (fire_i) begin
            pulse_o <= 1'b1;
            cnt_q   <= load_val;
        end else if (pulse_o) begin
            if (cnt_q == '0) pulse_o <= 1'b0;
            else             cnt_q   <= cnt_q - 1'b1;
        end
    end

    // R8: a low clear level leaves no pulse in the following cycle.
    assert_clear_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_i |=> !pulse_o);

    // R7: a running pulse only counts down; it is never reloaded.
    assert_no_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && clr_n_i && cnt_q != '0) |=> (pulse_o && cnt_q == $past(cnt_q) - 1'b1));

    // R6: an exhausted count ends the pulse.
    assert_pulse_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && cnt_q == '0) |=> !pulse_o);
endmodule

// File: rtl/dual_trig_oneshot.sv
// Dual-input non-retriggerable pulse generator (top).
// Synchronises the two trigger lines and the clear, qualifies starts and
// times the pulse in clock cycles. Assumes width_i is synchronous to clk.
module dual_trig_oneshot
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fall_trig_i,
    input  logic               rise_trig_i,
    input  logic               clr_n_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               pulse_o,
    output logic               pulse_n_o
);
    ctrl_lines_t      raw_lines;
    logic [CTRL_W-1:0] cur_vec, prev_vec;
    ctrl_lines_t      cur_lines, prev_lines;
    logic             sync_valid;
    logic             fire;
    logic             pulse_q;

    // Bundle the raw control lines.
    always_comb begin
        raw_lines.fall_trig = fall_trig_i;
        raw_lines.rise_trig = rise_trig_i;
        raw_lines.clr_n     = clr_n_i;
    end

    oneshot_sync #(.N(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (raw_lines),
        .cur_o   (cur_vec),
        .prev_o  (prev_vec),
        .valid_o (sync_valid)
    );

    assign cur_lines  = ctrl_lines_t'(cur_vec);
    assign prev_lines = ctrl_lines_t'(prev_vec);

    oneshot_trigger u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (sync_valid),
        .cur_i   (cur_lines),
        .prev_i  (prev_lines),
        .busy_i  (pulse_q),
        .fire_o  (fire)
    );

    oneshot_timer #(.WIDTH_W(WIDTH_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n_i (cur_lines.clr_n),
        .fire_i  (fire),
        .width_i (width_i),
        .pulse_o (pulse_q)
    );

    assign pulse_o   = pulse_q;
    assign pulse_n_o = ~pulse_q;

    // R3: an accepted start shows as a high output in the next cycle.
    assert_fire_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pulse_o);

    // R7: no start is accepted in a cycle where a pulse is already running.
    assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> !fire);
endmodule

// File: tb/tb_dual_trig_oneshot.sv
module tb_dual_trig_oneshot;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_r = 1'b0, b_r = 1'b0, c_r = 1'b1;
    logic [W-1:0] w_r = '0;
    logic pulse_o, pulse_n_o;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";
    bit mon_en = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    dual_trig_oneshot #(.WIDTH_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .fall_trig_i(a_r), .rise_trig_i(b_r),
        .clr_n_i(c_r), .width_i(w_r), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
    );

    // Expected pulse length from a width value (R6: zero counts as one).
    function automatic int exp_len(input logic [W-1:0] w);
        return (w == '0) ? 1 : int'(w);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-level reference: 2-flop sync, one-sample history, arming flag, counter.
    logic [2:0] m_s1, m_s2, m_p;  // [2]=fall line, [1]=rise line, [0]=clear
    int m_vc;
    bit m_arm, m_pulse;
    int m_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_p = '0; m_vc = 0;
            m_arm = 0; m_pulse = 0; m_cnt = 0;
        end else begin
            bit v, fa, fb, fc, fire;
            v  = (m_vc == 3);
            fa = m_p[2] && !m_s2[2] && m_s2[1] && m_s2[0];
            fb = !m_p[1] && m_s2[1] && !m_s2[2] && m_s2[0];
            fc = !m_p[0] && m_s2[0] && !m_s2[2] && m_s2[1] && m_arm;
            fire = v && !m_pulse && (fa || fb || fc);
            if (!m_s2[0]) begin m_pulse = 0; m_cnt = 0; end
            else if (fire) begin m_pulse = 1; m_cnt = exp_len(w_r) - 1; end
            else if (m_pulse) begin
                if (m_cnt == 0) m_pulse = 0; else m_cnt--;
            end
            if (v) begin
                if (fire) m_arm = 0;
                else if (m_s2[0] && (m_s2[2] || !m_s2[1])) m_arm = 1;
            end
            m_p = m_s2; m_s2 = m_s1; m_s1 = {a_r, b_r, c_r};
            if (m_vc < 3) m_vc++;
        end
    end

    // Per-cycle comparison against the model, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_en) begin
            chk(pulse_o == m_pulse, cur_req, pulse_o, m_pulse);
            chk(pulse_n_o == !pulse_o, "R2", pulse_n_o, !pulse_o);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Wait for a pulse to begin and count its length in cycles.
    task automatic measure(input int exp, input string tag);
        int t = 0;
        int n = 0;
        while (!pulse_o && t < 10) begin @(negedge clk); t++; end
        while (pulse_o && n < 400) begin n++; @(negedge clk); end
        chk(n == exp, tag, n, exp);
    endtask

    // Expect the output to stay low for n cycles.
    task automatic quiet(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (pulse_o) seen = 1; end
        chk(!seen, tag, seen, 0);
    endtask

    initial begin
        void'($urandom(32'd7331));
        cyc(3);
        @(negedge clk); rst_n = 1'b1;
        mon_en = 1'b1;
        // R1: idle after reset, including while the sync pipeline fills.
        cur_req = "R1";
        chk(pulse_o == 1'b0 && pulse_n_o == 1'b1, "R1", pulse_o, 0);
        quiet(8, "R1");

        // R3: falling trigger with the rise line high.
        cur_req = "R3"; w_r = 4;
        a_r = 1; b_r = 1; cyc(5);
        a_r = 0; measure(4, "R3");
        cyc(3);

        // R4: rising trigger with the fall line low.
        cur_req = "R4"; w_r = 6;
        b_r = 0; cyc(5);
        b_r = 1; measure(6, "R4");
        cyc(3);

        // R5: each line inhibits the other.
        cur_req = "R5";
        a_r = 1; b_r = 0; cyc(5);
        b_r = 1; quiet(8, "R5");
        b_r = 0; cyc(2);
        a_r = 0; quiet(8, "R5");

        // R6: zero width gives one cycle; width sampled at start only.
        cur_req = "R6"; b_r = 1; w_r = 0;
        a_r = 1; cyc(5); a_r = 0; measure(1, "R6");
        w_r = 1; a_r = 1; cyc(5); a_r = 0; measure(1, "R6");
        w_r = 9; a_r = 1; cyc(5); a_r = 0;
        fork
            measure(9, "R6");
            begin cyc(5); w_r = 2; end
        join
        cyc(3);

        // R7: activity during a pulse neither restarts nor extends it.
        cur_req = "R7"; w_r = 12;
        a_r = 1; cyc(5); a_r = 0;
        fork
            measure(12, "R7");
            begin
                cyc(4); a_r = 1; cyc(1); a_r = 0; cyc(1);
                b_r = 0; cyc(1); b_r = 1; cyc(1); a_r = 1; cyc(1); a_r = 0;
            end
        join
        cyc(3);

        // R8: clear ends a running pulse and blocks triggers while low.
        cur_req = "R8"; w_r = 20;
        a_r = 1; cyc(5); a_r = 0; cyc(6);
        chk(pulse_o == 1'b1, "R8", pulse_o, 1);
        c_r = 0; cyc(3);
        chk(pulse_o == 1'b0, "R8", pulse_o, 0);
        a_r = 1; cyc(2); a_r = 0; cyc(2); b_r = 0; cyc(2); b_r = 1;
        quiet(10, "R8");

        // R10: flag was cleared by the last start, so the release does not fire.
        cur_req = "R10";
        c_r = 1; quiet(10, "R10");

        // R9: armed flag lets a clear release fire.
        cur_req = "R9"; w_r = 7;
        a_r = 1; cyc(5); c_r = 0; cyc(5); a_r = 0; cyc(5);
        c_r = 1; measure(7, "R9");
        cyc(3);

        // R10: after that start the flag is clear again.
        cur_req = "R10";
        c_r = 0; cyc(5); c_r = 1; quiet(10, "R10");

        // Random traffic checked against the model (R7 and all others).
        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(3) == 0) a_r = ~a_r;
            if ($urandom_range(3) == 0) b_r = ~b_r;
            if ($urandom_range(15) == 0) c_r = ~c_r;
            else if (!c_r && $urandom_range(3) == 0) c_r = 1;
            w_r = W'($urandom_range(9));
        end
        cyc(20);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule